// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block measures how many master-clock cycles fit into one period of the frame (sample-rate) clock. It then decides which of four supported oversampling ratios the system is running at: 128, 256, 512 or 768 master clocks per frame. A measured period is accepted when it lies within a fixed tolerance of one of these ratios. When no ratio fits, the block drops its lock and asks the downstream converter to shut down and mute.

The frame clock comes in as a level that is already aligned to the master-clock domain. It still passes through a short synchronizer chain inside the block before its rising edges are detected. Measurement runs from one rising edge to the next.

Lock is granted only after two consecutive periods agree on the same ratio. This lets the detector ride out phase offset and small jitter between the two clocks. A frame clock that stops altogether is caught by a saturating period counter, which reports a timeout in place of a measurement.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While reset is low at a clock edge, the outputs become `locked`=0, `mute_req`=1 and `ratio_code`=0.
- R2: The block treats a rising edge of `frame_in` as seen three master-clock edges after the edge that first samples it high. Two edges are spent in the synchronizer, and one more registers the result. A period is the count of master clocks between two consecutive rising edges. The first rising edge after reset only starts a measurement and yields no result.
- R3: A period P matches ratio R when R-8 <= P <= R+8, for R in {128, 256, 512, 768}. The ratio code is 0 for 128, 1 for 256, 2 for 512 and 3 for 768. At most one ratio can match a given period.
- R4: `locked` rises only after two consecutive measured periods match the same ratio. It stays high while further periods keep matching that ratio.
- R5: A measured period that matches no ratio clears `locked` and sets `mute_req` on the next clock edge.
- R6: `mute_req` is always the inverse of `locked`.
- R7: A period that matches a ratio different from the previous matching period clears `locked`. That period becomes the new candidate, so one more agreeing period is enough to lock again.
- R8: If no rising edge is seen for CNT_MAX-2 cycles after the last one (CNT_MAX = 2^CNT_W-1), the counter saturates. The block then reports a mismatch: `locked` clears and `mute_req` sets. The next period after this counts as a mismatch too.
- R9: `ratio_code` takes the code of every matching period. It holds its value through mismatches and timeouts.
- R10: Periods that wander inside the ±8 window, including exactly R-8 and R+8, keep the block locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_in | input | 1 | Frame (sample-rate) clock level |
| ratio_code | output | 2 | Detected ratio: 0=128, 1=256, 2=512, 3=768 |
| locked | output | 1 | Two consecutive periods agree on one ratio |
| mute_req | output | 1 | Request to shut down and mute the converter |

## Verification
The assertions check four things on every cycle. Match windows never overlap. Lock only rises after a matching measurement. Mute tracks the inverse of lock. A mismatch or timeout drops lock on the following edge. They also check that the ratio code holds still without a match and that the counter restarts and saturates as intended. The bench scenarios are needed for the rest: exact synchronizer latency, the two-period acquisition, and relocking after a ratio change. They also cover the inclusive window edges at ±8 against a miss at -9, and the timeout of a stopped frame clock. A behavioural reference model follows every cycle of these scenarios.

// File: rtl/mcrd_pkg.sv
// Package: shared constants and helpers for the master clock ratio detector.
// Assumes the ratio set is fixed at four entries indexed by a 2-bit code.
package mcrd_pkg;

    localparam int unsigned NUM_RATIOS = 4;
    localparam int unsigned CODE_W     = 2;

    // Nominal master clocks per frame for a given ratio code.
    function automatic int unsigned ratio_of(input int unsigned idx);
        case (idx)
            0:       return 128;
            1:       return 256;
            2:       return 512;
            default: return 768;
        endcase
    endfunction

endpackage

// File: rtl/mcrd_sync_edge.sv
// Module: mcrd_sync_edge
// Brings the frame clock through a STAGES-deep flop chain and flags each
// rising edge for one master-clock cycle. Assumes frame_in changes no faster
// than every few master clocks.
module mcrd_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_in,
    output logic rise
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the frame level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], frame_in};
        end
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= sync_q[STAGES-1];
        end
    end

    // A rising edge is a high synchronized level after a low one.
    always_comb begin
        rise = sync_q[STAGES-1] & ~last_q;
    end

endmodule

// File: rtl/mcrd_period_counter.sv
// Module: mcrd_period_counter
// Counts master clocks between frame rising edges. The count saturates at
// CNT_MAX, and a one-cycle timeout pulse fires as it reaches saturation.
// The first edge after reset only primes the counter and gives no result.
module mcrd_period_counter #(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    output logic [CNT_W-1:0] period,
    output logic             meas_valid,
    output logic             timeout
);

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_NEAR = CNT_MAX - CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             primed_q;

    // Restart on each rising edge, otherwise count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (rise) begin
            cnt_q <= CNT_ONE;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    // Note that a first edge has been seen so later edges close a period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
        end else if (rise) begin
            primed_q <= 1'b1;
        end
    end

    // Present the running count as the measured period on an edge.
    always_comb begin
        period     = cnt_q;
        meas_valid = rise & primed_q;
        timeout    = ~rise & (cnt_q == CNT_NEAR);
    end

    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (cnt_q == CNT_ONE));

    assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !rise) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/mcrd_ratio_classifier.sv
// Module: mcrd_ratio_classifier
// Compares a measured period against each supported ratio's window of
// +/- TOL master clocks and encodes the hit. Assumes windows are disjoint,
// which holds while TOL stays well under half the smallest ratio gap.
module mcrd_ratio_classifier
    import mcrd_pkg::*;
#(
    parameter int unsigned CNT_W = 11,
    parameter int unsigned TOL   = 8
) (
    input  logic [CNT_W-1:0]      period,
    output logic [NUM_RATIOS-1:0] hit,
    output logic                  hit_any,
    output logic [CODE_W-1:0]     code
);

    for (genvar k = 0; k < NUM_RATIOS; k++) begin : g_window
        localparam int unsigned      LO_I = ratio_of(k) - TOL;
        localparam int unsigned      HI_I = ratio_of(k) + TOL;
        localparam logic [CNT_W-1:0] LO   = LO_I[CNT_W-1:0];
        localparam logic [CNT_W-1:0] HI   = HI_I[CNT_W-1:0];

        // Flag the period as inside this ratio's inclusive window.
        always_comb begin
            hit[k] = (period >= LO) && (period <= HI);
        end
    end

    // Encode the matching window index and note whether any matched.
    always_comb begin
        code    = '0;
        hit_any = 1'b0;
        for (int k = 0; k < NUM_RATIOS; k++) begin
            if (hit[k]) begin
                code    = CODE_W'(k);
                hit_any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mcrd_lock_tracker.sv
// Module: mcrd_lock_tracker
// Turns measurement events into lock, mute and ratio outputs. Lock needs two
// consecutive periods that agree on one ratio. A mismatch or timeout drops
// lock and requests mute at once. Assumes at most one event per cycle.
module mcrd_lock_tracker
    import mcrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meas_valid,
    input  logic              timeout,
    input  logic              hit_any,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] ratio_code,
    output logic              locked,
    output logic              mute_req
);

    logic              good_ev;
    logic              bad_ev;
    logic              agree;
    logic [CODE_W-1:0] cand_q;
    logic              cand_ok_q;
    logic [CODE_W-1:0] code_q;
    logic              locked_q;
    logic              mute_q;

    // Classify this cycle's event and whether it confirms the candidate.
    always_comb begin
        good_ev = meas_valid & hit_any;
        bad_ev  = (meas_valid & ~hit_any) | timeout;
        agree   = good_ev & cand_ok_q & (cand_q == code);
    end

    // Keep the last matching ratio as the candidate; a miss invalidates it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q    <= '0;
            cand_ok_q <= 1'b0;
        end else if (good_ev) begin
            cand_q    <= code;
            cand_ok_q <= 1'b1;
        end else if (bad_ev) begin
            cand_ok_q <= 1'b0;
        end
    end

    // Publish the code of every matching period, holding it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (good_ev) begin
            code_q <= code;
        end
    end

    // Grant lock on agreement, withdraw it on any other event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
        end else if (agree) begin
            locked_q <= 1'b1;
        end else if (good_ev || bad_ev) begin
            locked_q <= 1'b0;
        end
    end

    // Request mute whenever the detector is not confirmed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mute_q <= 1'b1;
        end else if (agree) begin
            mute_q <= 1'b0;
        end else if (good_ev || bad_ev) begin
            mute_q <= 1'b1;
        end
    end

    // Drive the outputs from their registers.
    always_comb begin
        ratio_code = code_q;
        locked     = locked_q;
        mute_req   = mute_q;
    end

    assert_lock_after_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_q) |-> $past(meas_valid && hit_any));

    assert_miss_mutes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((meas_valid && !hit_any) || timeout) |=> (!locked_q && mute_q));

    assert_mute_inverse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mute_q == !locked_q);

    assert_code_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(meas_valid && hit_any) |=> $stable(code_q));

endmodule

// File: rtl/mclk_ratio_detect.sv
// Module: mclk_ratio_detect (top)
// Measures master clocks per frame-clock period, matches the count to one
// of four oversampling ratios within +/- TOL, and reports lock and a
// shutdown/mute request. Assumes frame_in is already level-aligned to clk.
module mclk_ratio_detect
    import mcrd_pkg::*;
#(
    parameter int unsigned CNT_W       = 11,
    parameter int unsigned TOL         = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_in,
    output logic [1:0]  ratio_code,
    output logic        locked,
    output logic        mute_req
);

    logic                  rise;
    logic [CNT_W-1:0]      period;
    logic                  meas_valid;
    logic                  timeout;
    logic [NUM_RATIOS-1:0] hit;
    logic                  hit_any;
    logic [CODE_W-1:0]     code;

    mcrd_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_in (frame_in),
        .rise     (rise)
    );

    mcrd_period_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .period     (period),
        .meas_valid (meas_valid),
        .timeout    (timeout)
    );

    mcrd_ratio_classifier #(
        .CNT_W (CNT_W),
        .TOL   (TOL)
    ) u_class (
        .period  (period),
        .hit     (hit),
        .hit_any (hit_any),
        .code    (code)
    );

    mcrd_lock_tracker u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_valid (meas_valid),
        .timeout    (timeout),
        .hit_any    (hit_any),
        .code       (code),
        .ratio_code (ratio_code),
        .locked     (locked),
        .mute_req   (mute_req)
    );

    assert_one_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: tb/test_mclk_ratio_detect.sv
module test_mclk_ratio_detect;

    localparam int CNT_W   = 11;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_in = 1'b0;
    logic [1:0] ratio_code;
    logic       locked;
    logic       mute_req;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cycles  = 0;
    bit    started = 0;
    string cur_req = "R1";

    // Reference model state
    int m_hist[$];
    int m_cnt, m_primed, m_cand, m_cand_ok, m_code, m_locked;
    int ratios[4] = '{128, 256, 512, 768};

    always #4 clk = ~clk;

    mclk_ratio_detect i_mclk_ratio_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_in   (frame_in),
        .ratio_code (ratio_code),
        .locked     (locked),
        .mute_req   (mute_req)
    );

    function automatic int classify(input int p);
        foreach (ratios[k]) if (p >= ratios[k] - 8 && p <= ratios[k] + 8) return k;
        return -1;
    endfunction

    // Behavioural model: edge seen when the sample taken two edges ago is 1
    // and the one before it is 0.
    always @(posedge clk) begin
        started <= 1;
        cycles++;
        if (!rst_n) begin
            m_hist = '{0, 0, 0};
            m_cnt = 0; m_primed = 0; m_cand = 0; m_cand_ok = 0;
            m_code = 0; m_locked = 0;
        end else begin
            bit rise_now;
            rise_now = (m_hist[1] == 1) && (m_hist[2] == 0);
            if (rise_now) begin
                if (m_primed) begin
                    int k;
                    k = classify(m_cnt);
                    if (k >= 0) begin
                        m_locked = (m_cand_ok && m_cand == k);
                        m_cand = k; m_cand_ok = 1; m_code = k;
                    end else begin
                        m_locked = 0; m_cand_ok = 0;
                    end
                end
                m_primed = 1;
                m_cnt = 1;
            end else begin
                if (m_cnt == CNT_MAX - 1) begin
                    m_locked = 0; m_cand_ok = 0;
                end
                if (m_cnt < CNT_MAX) m_cnt++;
            end
            m_hist.push_front(int'(frame_in));
            void'(m_hist.pop_back());
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            n_tests++;
            if (locked !== m_locked[0] || mute_req !== !m_locked[0] ||
                ratio_code !== m_code[1:0]) begin
                n_fail++;
                $display("FAIL %s cycle %0d: locked=%b mute=%b code=%0d expected locked=%0d mute=%0d code=%0d",
                         cur_req, cycles, locked, mute_req, ratio_code,
                         m_locked, !m_locked[0], m_code);
            end
        end
    end

    task automatic expect_out(input string req, input bit exp_lock, input int exp_code);
        n_tests++;
        if (locked !== exp_lock || mute_req !== !exp_lock || ratio_code !== exp_code[1:0]) begin
            n_fail++;
            $display("FAIL %s: locked=%b mute=%b code=%0d expected locked=%0d mute=%0d code=%0d",
                     req, locked, mute_req, ratio_code, exp_lock, !exp_lock, exp_code);
        end
    endtask

    task automatic frame(input int p);
        for (int i = 0; i < p; i++) begin
            @(negedge clk);
            frame_in = (i < p / 2);
        end
    endtask

    task automatic frames(input int p, input int n);
        for (int j = 0; j < n; j++) frame(p);
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not end, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        expect_out("R1 reset", 0, 0);
        rst_n = 1;

        cur_req = "R2";
        frames(256, 2);
        expect_out("R2 first edge only primes", 0, 1);
        cur_req = "R4";
        frame(256);
        expect_out("R4 lock after two matches", 1, 1);

        cur_req = "R10";
        frame(264); frame(248); frame(264); frame(248);
        expect_out("R10 jitter at window edges", 1, 1);

        cur_req = "R5";
        frame(265); frame(256);
        expect_out("R5 mismatch mutes", 0, 1);
        cur_req = "R9";
        expect_out("R9 code held through miss", 0, 1);
        frames(256, 2);
        expect_out("R4 relock", 1, 1);

        cur_req = "R7";
        frame(512); frame(512);
        expect_out("R7 ratio change drops lock", 0, 2);
        frame(512);
        expect_out("R7 relock on new ratio", 1, 2);

        cur_req = "R3";
        frames(128, 3);
        expect_out("R3 ratio 128", 1, 0);
        frames(768, 3);
        expect_out("R3 ratio 768", 1, 3);
        frames(520, 3);
        expect_out("R3 window top 520", 1, 2);
        frame(503); frame(512);
        expect_out("R3 503 misses", 0, 2);
        frames(512, 2);
        expect_out("R3 relock 512", 1, 2);

        cur_req = "R8";
        frames(256, 3);
        expect_out("R8 locked before stall", 1, 1);
        repeat (CNT_MAX + 100) @(negedge clk);
        expect_out("R8 stalled frame mutes", 0, 1);
        frames(256, 3);
        expect_out("R8 recovery", 1, 1);

        cur_req = "R1";
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        expect_out("R1 mid-run reset", 0, 0);
        rst_n = 1;
        repeat (5) @(negedge clk);
        expect_out("R1 held after reset", 0, 0);

        finish_run();
    end

endmodule